// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes an incoming Ethernet frame as a byte stream, framed by start and end markers, and stores it in a circular buffer in local packet memory. The buffer is organised in fixed pages of 256 bytes. The ring is bounded by a first page and an exclusive last page. Each stored frame occupies a whole number of pages. The frame's first four bytes are a status and link header. The header carries the page where the next frame will begin, which lets the host walk the ring from one frame to the next.

Before it accepts a frame, the block compares the free space against a boundary page that the host owns. It refuses the frame when there may not be room for a maximum-size frame, when the ring bounds are inconsistent, or while the host holds the receiver halted. A refused frame is still consumed so the source never stalls, but it does not reach memory. For an accepted frame, the payload is written from byte 4 of the current page onward, wrapping from the ring end back to the ring start. Once the end marker arrives, the four header bytes are written with the input held off. The current-page pointer then advances and a sticky receive flag is raised. The memory itself is a plain byte-write port outside the block.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `cur_page` is 0, `rx_flag` is 0, `in_ready` is 1 and `mem_we` is 0.
- R2: When `ring_stop` is less than or equal to `ring_start`, every frame is refused.
- R3: Free bytes are computed from the pages. If `cur_page` < `bnd_page`, they are (`bnd_page` − `cur_page`)·256. Otherwise they are (`ring_stop` − `ring_start` − (`cur_page` − `bnd_page`))·256. A frame is refused when free bytes are below 1518, so 5 free pages refuse a frame and 6 accept one.
- R4: While `rx_halt` is 1, every frame is refused.
- R5: A frame is refused on its start beat. It is still consumed to its end marker with `in_ready` high and `in_drop` high on every consumed beat. It produces no memory write and leaves `cur_page` and `rx_flag` unchanged. Beats that arrive outside a frame are consumed without any write.
- R6: Header byte 0 is the receive status. Bit 0 is always 1. Bit 5 is 1 exactly when bit 0 of the frame's first byte is 1, which gives 0x01 or 0x21.
- R7: Header byte 1 is the next page. Bytes 2 and 3 carry the total length (frame bytes + 4), with the low byte in byte 2.
- R8: The next page is `cur_page` + floor((frame bytes + 8 + 255)/256). When that sum is at or above `ring_stop`, (`ring_stop` − `ring_start`) is subtracted from it.
- R9: Frame byte k goes to address `cur_page`·256 + 4 + k. When an address reaches `ring_stop`·256, writing continues at `ring_start`·256.
- R10: For the four cycles after the end-marker beat, `in_ready` is 0. In those cycles the header bytes 0..3 are written to `cur_page`·256 + 0..3, in that order.
- R11: In the cycle after the last header byte, `cur_page` holds the next page and `rx_flag` is 1. A `flag_clr` pulse clears `rx_flag`, unless a frame completes in the same cycle, in which case the flag is set.
- R12: A `cur_load` pulse while no frame is in progress loads `cur_page` from `cur_load_pg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_start | input | PG_W | First page of the ring |
| ring_stop | input | PG_W | Page just past the ring end |
| bnd_page | input | PG_W | Host boundary page |
| rx_halt | input | 1 | Refuse all frames while high |
| cur_load | input | 1 | Load the current page |
| cur_load_pg | input | PG_W | Value for cur_load |
| flag_clr | input | 1 | Clear the receive flag |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_ready | output | 1 | Block can take a byte |
| in_drop | output | 1 | Current beat belongs to a refused frame |
| mem_we | output | 1 | Packet memory byte write |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 8 | Write data |
| cur_page | output | PG_W | Current page pointer |
| rx_flag | output | 1 | Sticky receive-complete flag |

## Verification
The bench builds the block with its default parameters: 8-bit page numbers, 256-byte pages, a 16-bit address and a 1514-byte maximum frame. It places a 12-page ring at pages 0x40 to 0x4B. With a ring that small, random frames of up to 1514 bytes wrap both the data addresses and the next-page value within a few frames. Keeping the boundary still between frames drives the free-space check across its 5-page and 6-page edge.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_DATA = 2'd1,
      RX_DROP = 2'd2,
      RX_HDR  = 2'd3
   } rx_st_e;

   localparam int HDR_BYTES = 4;
   localparam int CRC_BYTES = 4;
   localparam logic [7:0] ST_OK_BIT = 8'h01;
   localparam logic [7:0] ST_GRP_BIT = 8'h20;
endpackage

// File: rtl/rxr_room_check.sv
module rxr_room_check #(
   parameter int PG_W      = 8,
   parameter int OFF_W     = 8,
   parameter int MAX_FRAME = 1514
) (
   input  logic [PG_W-1:0] start_pg,
   input  logic [PG_W-1:0] stop_pg,
   input  logic [PG_W-1:0] cur_pg,
   input  logic [PG_W-1:0] bnd_pg,
   output logic            room_ok
);
   localparam int BW = PG_W + OFF_W + 2;
   localparam logic [BW-1:0] NEED = BW'(MAX_FRAME + rxr_pkg::CRC_BYTES);

   logic [PG_W:0] ring_pg;
   logic [PG_W:0] used_pg;
   logic [PG_W:0] free_pg;
   logic [BW-1:0] free_b;

   always_comb begin
      ring_pg = {1'b0, stop_pg} - {1'b0, start_pg};
      used_pg = {1'b0, cur_pg} - {1'b0, bnd_pg};
      free_pg = '0;
      room_ok = 1'b0;
      if (stop_pg > start_pg) begin
         if (cur_pg < bnd_pg) begin
            free_pg = {1'b0, bnd_pg} - {1'b0, cur_pg};
            room_ok = 1'b1;
         end else if (used_pg <= ring_pg) begin
            free_pg = ring_pg - used_pg;
            room_ok = 1'b1;
         end
      end
      free_b = BW'(free_pg) << OFF_W;
      if (free_b < NEED) room_ok = 1'b0;
   end
endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page #(
   parameter int PG_W  = 8,
   parameter int OFF_W = 8,
   parameter int LEN_W = 16
) (
   input  logic [PG_W-1:0]  cur_pg,
   input  logic [PG_W-1:0]  start_pg,
   input  logic [PG_W-1:0]  stop_pg,
   input  logic [LEN_W-1:0] frame_len,
   output logic [PG_W-1:0]  next_pg
);
   localparam int SW = ((LEN_W > PG_W) ? LEN_W : PG_W) + 2;
   localparam logic [SW-1:0] PAD =
      SW'(rxr_pkg::HDR_BYTES + rxr_pkg::CRC_BYTES + (1 << OFF_W) - 1);

   logic [SW-1:0] span;
   logic [SW-1:0] sum;

   always_comb begin
      span = (SW'(frame_len) + PAD) >> OFF_W;
      sum  = SW'(cur_pg) + span;
      if (sum >= SW'(stop_pg))
         sum = sum - (SW'(stop_pg) - SW'(start_pg));
      next_pg = sum[PG_W-1:0];
   end
endmodule

// File: rtl/rxr_addr_step.sv
module rxr_addr_step #(
   parameter int PG_W  = 8,
   parameter int OFF_W = 8
) (
   input  logic [PG_W+OFF_W-1:0] addr,
   input  logic [PG_W-1:0]       start_pg,
   input  logic [PG_W-1:0]       stop_pg,
   output logic [PG_W+OFF_W-1:0] addr_nxt
);
   localparam int AW = PG_W + OFF_W;
   logic [AW-1:0] inc;

   always_comb begin
      inc = addr + AW'(1);
      if (inc == {stop_pg, {OFF_W{1'b0}}})
         addr_nxt = {start_pg, {OFF_W{1'b0}}};
      else
         addr_nxt = inc;
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
   parameter int PG_W      = 8,
   parameter int OFF_W     = 8,
   parameter int ADDR_W    = 16,
   parameter int LEN_W     = 16,
   parameter int MAX_FRAME = 1514
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PG_W-1:0]   ring_start,
   input  logic [PG_W-1:0]   ring_stop,
   input  logic [PG_W-1:0]   bnd_page,
   input  logic              rx_halt,
   input  logic              cur_load,
   input  logic [PG_W-1:0]   cur_load_pg,
   input  logic              flag_clr,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_sof,
   input  logic              in_eof,
   output logic              in_ready,
   output logic              in_drop,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic [PG_W-1:0]   cur_page,
   output logic              rx_flag
);
   import rxr_pkg::*;

   localparam int HIDX_W = $clog2(HDR_BYTES);

   if (ADDR_W != PG_W + OFF_W) begin : g_bad_addr
      $error("ADDR_W must equal PG_W + OFF_W");
   end
   if (OFF_W < HIDX_W + 1) begin : g_bad_off
      $error("page offset too narrow for the header");
   end
   if ((1 << LEN_W) <= MAX_FRAME + HDR_BYTES) begin : g_bad_len
      $error("LEN_W too narrow for MAX_FRAME");
   end

   rx_st_e              st;
   logic [ADDR_W-1:0]   wr_addr;
   logic [ADDR_W-1:0]   addr_now;
   logic [ADDR_W-1:0]   addr_nxt;
   logic [LEN_W-1:0]    len_q;
   logic [LEN_W-1:0]    tot_len;
   logic                grp_q;
   logic [HIDX_W-1:0]   hidx;
   logic [PG_W-1:0]     cur_q;
   logic [PG_W-1:0]     next_pg;
   logic                flag_q;
   logic                room_ok;
   logic                beat;
   logic                st_idle;
   logic                take_sof;
   logic                accept_sof;
   logic                refuse_sof;
   logic                data_wr;
   logic                hdr_last;
   logic [7:0]          hdr_byte [HDR_BYTES];
   logic [7:0]          hdr_sel;

   rxr_room_check #(.PG_W(PG_W), .OFF_W(OFF_W), .MAX_FRAME(MAX_FRAME)) u_room (
      .start_pg (ring_start),
      .stop_pg  (ring_stop),
      .cur_pg   (cur_q),
      .bnd_pg   (bnd_page),
      .room_ok  (room_ok)
   );

   rxr_next_page #(.PG_W(PG_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_next (
      .cur_pg    (cur_q),
      .start_pg  (ring_start),
      .stop_pg   (ring_stop),
      .frame_len (len_q),
      .next_pg   (next_pg)
   );

   rxr_addr_step #(.PG_W(PG_W), .OFF_W(OFF_W)) u_step (
      .addr     (addr_now),
      .start_pg (ring_start),
      .stop_pg  (ring_stop),
      .addr_nxt (addr_nxt)
   );

   assign st_idle    = (st == RX_IDLE);
   assign in_ready   = (st != RX_HDR);
   assign beat       = in_valid & in_ready;
   assign take_sof   = st_idle & beat & in_sof;
   assign accept_sof = take_sof & ~rx_halt & room_ok;
   assign refuse_sof = take_sof & ~accept_sof;
   assign data_wr    = accept_sof | ((st == RX_DATA) & beat);
   assign hdr_last   = (st == RX_HDR) && (hidx == HIDX_W'(HDR_BYTES - 1));
   assign in_drop    = refuse_sof | ((st == RX_DROP) & in_valid);
   assign addr_now   = st_idle ? {cur_q, OFF_W'(HDR_BYTES)} : wr_addr;
   assign tot_len    = len_q + LEN_W'(HDR_BYTES);

   assign hdr_byte[0] = ST_OK_BIT | (grp_q ? ST_GRP_BIT : 8'h00);
   assign hdr_byte[1] = 8'(next_pg);
   for (genvar g = 2; g < HDR_BYTES; g++) begin : g_len_byte
      assign hdr_byte[g] = 8'(tot_len >> (8 * (g - 2)));
   end
   assign hdr_sel = hdr_byte[hidx];

   always_comb begin
      mem_we    = data_wr | (st == RX_HDR);
      mem_addr  = addr_now;
      mem_wdata = in_data;
      if (st == RX_HDR) begin
         mem_addr  = {cur_q, OFF_W'(hidx)};
         mem_wdata = hdr_sel;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         wr_addr <= '0;
         len_q   <= '0;
         grp_q   <= 1'b0;
         hidx    <= '0;
         cur_q   <= '0;
      end else begin
         case (st)
            RX_IDLE: begin
               if (cur_load) cur_q <= cur_load_pg;
               hidx <= '0;
               if (accept_sof) begin
                  len_q   <= LEN_W'(1);
                  grp_q   <= in_data[0];
                  wr_addr <= addr_nxt;
                  st      <= in_eof ? RX_HDR : RX_DATA;
               end else if (refuse_sof && !in_eof) begin
                  st <= RX_DROP;
               end
            end
            RX_DATA: begin
               if (beat) begin
                  len_q   <= len_q + LEN_W'(1);
                  wr_addr <= addr_nxt;
                  if (in_eof) st <= RX_HDR;
               end
            end
            RX_DROP: begin
               if (beat && in_eof) st <= RX_IDLE;
            end
            RX_HDR: begin
               hidx <= hidx + HIDX_W'(1);
               if (hdr_last) begin
                  cur_q <= next_pg;
                  st    <= RX_IDLE;
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hdr_last) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign cur_page = cur_q;
   assign rx_flag  = flag_q;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
   parameter int PG_W   = 8,
   parameter int OFF_W  = 8,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PG_W-1:0]   ring_start,
   input logic [PG_W-1:0]   ring_stop,
   input logic              rx_halt,
   input logic              cur_load,
   input logic              in_valid,
   input logic              in_sof,
   input logic              in_ready,
   input logic              in_drop,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [PG_W-1:0]   cur_page,
   input logic              rx_flag,
   input logic              st_idle,
   input logic              hdr_last
);
   AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      in_drop |-> !mem_we); // R5

   AST_HALT_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (st_idle && in_valid && in_sof && rx_halt) |-> in_drop); // R4

   AST_BAD_RING_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (st_idle && in_valid && in_sof && (ring_stop <= ring_start)) |-> in_drop); // R2

   AST_HDR_AT_PAGE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !in_ready) |-> (mem_addr[OFF_W-1:2] == '0)); // R10

   AST_FLAG_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_last |=> rx_flag); // R11

   AST_CUR_MOVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_page != $past(cur_page)) |-> ($past(hdr_last) || $past(cur_load))); // R11
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PG_W(PG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ring_start (ring_start),
   .ring_stop  (ring_stop),
   .rx_halt    (rx_halt),
   .cur_load   (cur_load),
   .in_valid   (in_valid),
   .in_sof     (in_sof),
   .in_ready   (in_ready),
   .in_drop    (in_drop),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .cur_page   (cur_page),
   .rx_flag    (rx_flag),
   .st_idle    (st_idle),
   .hdr_last   (hdr_last)
);

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ring_start = 8'h40, ring_stop = 8'h4C, bnd_page = 8'h40;
   logic        rx_halt = 1'b0, cur_load = 1'b0, flag_clr = 1'b0;
   logic [7:0]  cur_load_pg = 8'h00;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready, in_drop, mem_we, rx_flag;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, cur_page;

   rx_ring_writer u0 (.*);

   always #2 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   int wr_count = 0;
   logic [7:0] mem [int];
   logic [7:0] pl [0:2047];
   bit drop_seen, drop_all;

   always @(posedge clk) if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_count++;
   end

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic bit m_room(int cur, int bnd, int st, int sp);
      int avail;
      if (sp <= st) return 0;
      if (cur < bnd) avail = (bnd - cur) * 256;
      else avail = ((sp - st) - (cur - bnd)) * 256;
      return avail >= 1518;
   endfunction

   function automatic int m_next(int cur, int len, int st, int sp);
      int n = cur + ((len + 8 + 255) >> 8);
      if (n >= sp) n -= (sp - st);
      return n;
   endfunction

   task automatic fill(int len);
      for (int i = 0; i < len; i++) pl[i] = 8'($urandom);
   endtask

   task automatic send(int len);
      drop_all = 1;
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1; in_data = pl[i];
         in_sof = (i == 0); in_eof = (i == len - 1);
         #1;
         while (!in_ready) begin @(negedge clk); #1; end
         if (i == 0) drop_seen = in_drop;
         if (!in_drop) drop_all = 0;
         @(negedge clk);
      end
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic load_cur(int pg);
      cur_load_pg = 8'(pg); cur_load = 1'b1;
      @(negedge clk); cur_load = 1'b0;
      check("R12 cur_load", int'(cur_page), pg);
   endtask

   task automatic verify(int cur0, int len);
      int a, nx, tot, bad;
      tot = len + 4;
      nx = m_next(cur0, len, int'(ring_start), int'(ring_stop));
      check("R6 status", int'(mem[cur0*256]), pl[0][0] ? 8'h21 : 8'h01);
      check("R7 next page byte", int'(mem[cur0*256+1]), nx);
      check("R7 length low", int'(mem[cur0*256+2]), tot & 255);
      check("R7 length high", int'(mem[cur0*256+3]), tot >> 8);
      a = cur0*256 + 4; bad = 0;
      for (int i = 0; i < len; i++) begin
         if (mem[a] != pl[i]) bad++;
         a++;
         if (a == int'(ring_stop)*256) a = int'(ring_start)*256;
      end
      check("R9 data bytes wrong", bad, 0);
      check("R8 cur_page advanced", int'(cur_page), nx);
      check("R11 flag set", int'(rx_flag), 1);
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      check("R11 flag cleared", int'(rx_flag), 0);
   endtask

   task automatic expect_drop(string req, int len);
      int c0, w0;
      c0 = int'(cur_page); w0 = wr_count;
      fill(len); send(len); idle(6);
      check({req, " drop flag at start"}, int'(drop_seen), 1);
      check({"R5 drop on all beats ", req}, int'(drop_all), 1);
      check({"R5 no write ", req}, wr_count - w0, 0);
      check({"R5 cur held ", req}, int'(cur_page), c0);
      check({"R5 flag held ", req}, int'(rx_flag), 0);
   endtask

   task automatic accept_frame(int len);
      int c0 = int'(cur_page);
      send(len); idle(6);
      check("R3 accepted", int'(drop_seen), 0);
      verify(c0, len);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 cur_page", int'(cur_page), 0);
      check("R1 rx_flag", int'(rx_flag), 0);
      check("R1 in_ready", int'(in_ready), 1);
      check("R1 mem_we", int'(mem_we), 0);
      @(negedge clk);

      // stray beats outside a frame
      begin
         int w0 = wr_count;
         in_valid = 1; in_data = 8'hAA; @(negedge clk); @(negedge clk); in_valid = 0;
         check("R5 stray beats no write", wr_count - w0, 0);
      end

      load_cur(8'h40);
      // R3 boundary: 5 free pages refuse, 6 accept
      bnd_page = 8'h45;
      expect_drop("R3 five pages", 200);
      bnd_page = 8'h46;
      fill(1000); pl[0] = 8'h01;
      send(1000);
      // R10 ready low for four cycles after end beat
      for (int k = 0; k < 4; k++) begin
         check("R10 ready low in header", int'(in_ready), 0);
         check("R10 cur not yet moved", int'(cur_page), 8'h40);
         @(negedge clk);
      end
      check("R10 ready back", int'(in_ready), 1);
      check("R11 cur at next page", int'(cur_page), 8'h44);
      idle(2);
      verify(8'h40, 1000);

      // one-byte frame, unicast status
      bnd_page = cur_page;
      fill(1); pl[0] = 8'h02;
      accept_frame(1);

      // wrap of data and next page
      load_cur(8'h4A); bnd_page = 8'h4A;
      fill(1000); pl[0] = 8'h10;
      accept_frame(1000);
      check("R8 wrapped next", int'(cur_page), 8'h42);

      // halt
      bnd_page = cur_page; rx_halt = 1'b1;
      expect_drop("R4 halt", 64);
      rx_halt = 1'b0;

      // bad ring bounds
      ring_stop = 8'h40;
      expect_drop("R2 stop equals start", 64);
      ring_stop = 8'h30;
      expect_drop("R2 stop below start", 64);
      ring_stop = 8'h4C;

      // constrained random frames
      for (int f = 0; f < 24; f++) begin
         int len = int'($urandom_range(1, 1514));
         bit ok;
         if ($urandom_range(0, 2) != 0) bnd_page = cur_page;
         ok = m_room(int'(cur_page), int'(bnd_page), int'(ring_start), int'(ring_stop));
         if (ok) begin
            fill(len); accept_frame(len);
         end else begin
            expect_drop("R3 random full", len);
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #600000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule